// File: doc/BRIEF.md
# Conditional-Block State Advancer

This unit keeps the eight-bit state that controls a run of conditionally executed instructions in a compressed instruction set. It holds a 32-bit status word. The state is spread over bits 15:10 and 26:25 of that word. The top four bits, 15:12, carry the condition that currently applies. The five-bit step mask is formed from bits 12, 11, 10, 26 and 25, most significant first.

Each time an instruction retires, the surrounding pipeline pulses the advance strobe. The unit then shifts the mask so that the next instruction in the block picks up its condition. When the last instruction of the block has been used, the unit clears the condition field, which ends the block without any further action.

A load strobe replaces the whole word, for example when a status word is restored. Both strobes are plain control pins with no handshake, because the unit accepts one operation in every cycle. The outputs reflect the registered word, and each operation appears on them one cycle after the strobe.

Top module: `cblk_state_advancer`

## Requirements
- R1: While reset is high, at the next clock edge the status word, the active flag and the condition output all become zero.
- R2: When the load strobe is high, the status word equals the load value after the next clock edge.
- R3: When load and advance are high in the same cycle, the load wins and no advance is applied.
- R4: On an advance, let the four-bit value m be bits {11,10,26,25} of the word. If m is non-zero, the word after the edge has bit12=m[3], bit11=m[2], bit10=m[1], bit26=m[0] and bit25=0.
- R5: On an advance where m equals 4'b1000, bits 15:12 become zero after the edge. As a result, the active flag falls and the condition output becomes zero.
- R6: On an advance where m is zero, the word is unchanged.
- R7: An advance never changes any bit outside 15:10 and 26:25.
- R8: The active flag is high exactly when any of bits 11, 10, 26 and 25 of the output word is set.
- R9: The condition output always equals bits 15:12 of the output word.
- R10: With neither strobe high, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Step the conditional state by one instruction |
| load_i | input | 1 | Replace the status word with load_word_i |
| load_word_i | input | 32 | Status word to load |
| status_o | output | 32 | Registered status word |
| active_o | output | 1 | A conditional block is in progress |
| cond_o | output | 4 | Condition currently in force |

## Verification
The hardest point to reach is the terminal step. On that step the mask has only its top bit left, and the same advance that shifts the mask also clears the condition field.

To get there from the ports, the bench loads words whose mask encodes blocks of one, two, three and four instructions. It then advances until each block is exhausted, so that the clearing step is entered from every possible block length. An extra advance after each block confirms the idle case.

The bench also loads words with all the other bits set. This shows that the shifting never disturbs bits outside the conditional state.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned COND_LO  = 12;
  localparam int unsigned MASK_N   = 5;
  // Bit positions of the step mask, most significant first.
  localparam int unsigned MASK_POS [MASK_N] = '{12, 11, 10, 26, 25};
  // Bits an advance may touch: 15:10 and 26:25.
  localparam logic [STAT_W-1:0] STATE_BITS = 32'h0600_FC00;

  typedef logic [MASK_N-1:0] mask_t;
  typedef logic [COND_W-1:0] cond_t;
endpackage

// File: rtl/cblk_field_view.sv
module cblk_field_view
  import cblk_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic [W-1:0] word_i,
  output mask_t        mask_o,
  output cond_t        cond_o,
  output logic         active_o
);
  localparam int unsigned COND_HI = COND_LO + COND_W - 1;

  for (genvar g = 0; g < MASK_N; g++) begin : g_gather
    assign mask_o[MASK_N-1-g] = word_i[MASK_POS[g]];
  end

  assign cond_o   = word_i[COND_HI:COND_LO];
  // Only the four low mask bits say whether a block is running.
  assign active_o = |mask_o[MASK_N-2:0];
endmodule

// File: rtl/cblk_step_logic.sv
module cblk_step_logic
  import cblk_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic [W-1:0] word_i,
  input  mask_t        mask_i,
  output logic [W-1:0] next_o
);
  localparam int unsigned COND_HI = COND_LO + COND_W - 1;

  mask_t shifted;
  assign shifted = {mask_i[MASK_N-2:0], 1'b0};

  always_comb begin
    next_o = word_i;
    if (mask_i[MASK_N-2:0] != '0) begin
      for (int i = 0; i < MASK_N; i++) begin
        next_o[MASK_POS[i]] = shifted[MASK_N-1-i];
      end
      if (shifted[MASK_N-2:0] == '0) begin
        next_o[COND_HI:COND_LO] = '0;
      end
    end
  end
endmodule

// File: rtl/cblk_state_reg.sv
module cblk_state_reg #(
  parameter int unsigned W = cblk_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] load_word_i,
  input  logic [W-1:0] step_word_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= load_word_i;
    end else if (adv_i) begin
      q_o <= step_word_i;
    end
  end
endmodule

// File: rtl/cblk_state_advancer.sv
module cblk_state_advancer
  import cblk_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_word_i,
  output logic [W-1:0] status_o,
  output logic         active_o,
  output logic [3:0]   cond_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_nx;
  mask_t        mask;

  cblk_field_view #(.W(W)) view_i (
    .word_i   (word_q),
    .mask_o   (mask),
    .cond_o   (cond_o),
    .active_o (active_o)
  );

  cblk_step_logic #(.W(W)) step_i (
    .word_i (word_q),
    .mask_i (mask),
    .next_o (word_nx)
  );

  cblk_state_reg #(.W(W)) reg_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .load_word_i (load_word_i),
    .step_word_i (word_nx),
    .q_o         (word_q)
  );

  assign status_o = word_q;
endmodule

// File: rtl/cblk_state_advancer_chk.sv
module cblk_state_advancer_chk (
  input logic        clk,
  input logic        rst,
  input logic        adv_i,
  input logic        load_i,
  input logic [31:0] load_word_i,
  input logic [31:0] status_o,
  input logic        active_o,
  input logic [3:0]  cond_o
);
  localparam logic [31:0] KEEP = ~cblk_pkg::STATE_BITS;

  logic [3:0] m4;
  assign m4 = {status_o[11], status_o[10], status_o[26], status_o[25]};

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> status_o == $past(load_word_i));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i) |=> status_o == $past(load_word_i));

  assert_last_step_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && m4 == 4'b1000) |=> (!active_o && cond_o == 4'h0));

  assert_idle_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && m4 == 4'h0) |=> $stable(status_o));

  assert_outer_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> (status_o & KEEP) == ($past(status_o) & KEEP));

  assert_active_flag_R8: assert property (@(posedge clk) disable iff (rst)
    active_o == (m4 != 4'h0));

  assert_cond_field_R9: assert property (@(posedge clk) disable iff (rst)
    cond_o == status_o[15:12]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> $stable(status_o));
endmodule

bind cblk_state_advancer cblk_state_advancer_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .adv_i       (adv_i),
  .load_i      (load_i),
  .load_word_i (load_word_i),
  .status_o    (status_o),
  .active_o    (active_o),
  .cond_o      (cond_o)
);

// File: tb/cblk_state_advancer_tb_top.sv
module cblk_state_advancer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_word_i = '0;
  logic [31:0] status_o;
  logic        active_o;
  logic [3:0]  cond_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cblk_state_advancer dut_i (
    .clk         (clk),
    .rst         (rst),
    .adv_i       (adv_i),
    .load_i      (load_i),
    .load_word_i (load_word_i),
    .status_o    (status_o),
    .active_o    (active_o),
    .cond_o      (cond_o)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] s);
    logic [31:0] r;
    logic [3:0]  m;
    r = s;
    m = {s[11], s[10], s[26], s[25]};
    if (m != 4'h0) begin
      r[12] = m[3];
      r[11] = m[2];
      r[10] = m[1];
      r[26] = m[0];
      r[25] = 1'b0;
      if (m[2:0] == 3'b000) r[15:12] = 4'h0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input bit adv,
                       input logic [31:0] val, input string tag);
    exp_t e;
    @(negedge clk);
    load_i      = ld;
    adv_i       = adv;
    load_word_i = val;
    if (ld)       model = val;
    else if (adv) model = ref_step(model);
    e.word = model;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each result shortly after the edge that produced it.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] m;
      e = sb_q.pop_front();
      m = {e.word[11], e.word[10], e.word[26], e.word[25]};
      check(e.tag, "word", status_o, e.word);
      check("R8", "active", {31'b0, active_o}, {31'b0, m != 4'h0});
      check("R9", "cond", {28'b0, cond_o}, {28'b0, e.word[15:12]});
    end
  end

  // Loads a block then advances until it is exhausted, plus one extra.
  task automatic run_block(input logic [31:0] w, input int steps);
    drive(1'b1, 1'b0, w, "R2");
    for (int i = 0; i < steps - 1; i++) drive(1'b0, 1'b1, '0, "R4");
    drive(1'b0, 1'b1, '0, "R5");
    drive(1'b0, 1'b1, '0, "R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "word", status_o, 32'h0);
    check("R1", "active", {31'b0, active_o}, 32'h0);
    check("R1", "cond", {28'b0, cond_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    drive(1'b0, 1'b1, '0, "R6");
    // Block of one: mask 1000 (bit11), condition 0xA with bit12 = 0.
    run_block(32'h0000_A800, 1);
    // Block of two: mask 0100 (bit10).
    run_block(32'h0000_B400, 2);
    // Block of three: mask 0010 (bit26).
    run_block(32'h0400_C000, 3);
    // Block of four: mask 0001 (bit25).
    run_block(32'h0200_D000, 4);
    // Other bits set: R7 with a full mask.
    run_block(32'hFFFF_FFFF, 4);
    run_block(32'hA5A5_5A5A | 32'h0000_0800, 1);
    // Load priority over advance.
    drive(1'b1, 1'b0, 32'h1234_7C00, "R2");
    drive(1'b1, 1'b1, 32'h0600_E400, "R3");
    drive(1'b0, 1'b0, '0, "R10");
    drive(1'b0, 1'b0, 32'hFFFF_FFFF, "R10");
    drive(1'b0, 1'b1, '0, "R7");
    drive(1'b0, 1'b0, '0, "R10");
    // Reset in the middle of a block.
    drive(1'b1, 1'b0, 32'h0000_9C00, "R2");
    @(negedge clk);
    adv_i = 1'b1;
    load_i = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1", "word", status_o, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    adv_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule